// File: doc/BRIEF.md
# Eight-Channel Interrupt Controller

This block gathers eight interrupt request lines from on-chip peripherals and external pins and turns them into a single interrupt request for the CPU. A rising edge on a request line marks that channel pending. The lowest-numbered pending channel that is enabled is chosen, and its number is latched. The block then raises the CPU request and holds it until software acknowledges that channel.

Software sees one 32-bit control word. Through it, software turns the whole unit on or off, enables each channel on its own, reads the number of the channel being served, and acknowledges it. Software can also mark any channel pending with a trigger field that clears itself. The conventional channel use is: 0 watchdog, 1 spare, 2 pin change, 3 serial port, 4 SPI done, 5 two-wire done, 6 and 7 external pins. The output feeds the CPU's machine external interrupt.

Top module: `irq_hub`

## Requirements
- R1: After reset, `rd_data` reads 0 and `cpu_irq` is low.
- R2: Bit 4 (unit enable) and bits 15:8 (bit 8+n enables channel n) read back as last written. Bit 3, bits 19:16 and all other bits outside 2:0 always read 0.
- R3: While bit 4 is 0, `cpu_irq` stays low. Edges seen while the unit is off still set pending flags, and those flags are served once the unit is turned on.
- R4: A rising edge on `irq_req[n]` sets the pending flag of channel n. If the request line is low just before a clock edge and high at that edge, and the channel is enabled and no channel is being served, `cpu_irq` is high one cycle after that edge. A line held high sets the flag only once.
- R5: When several enabled channels are pending, the lowest index is selected. While `cpu_irq` is high, bits 2:0 hold the index of the selected channel.
- R6: The latched index does not change until it is acknowledged, even if a lower-numbered channel becomes pending in the meantime.
- R7: A write with bit 3 set while `cpu_irq` is high clears that channel's pending flag and drops `cpu_irq` after that edge. The next pending channel is selected one cycle later.
- R8: A channel whose enable bit is 0 ignores edges. Clearing its enable discards its pending flag and withdraws `cpu_irq` if that channel is being served.
- R9: A write with bit 19 set and a channel number in bits 18:16 sets that channel's pending flag, subject to R8, using the enables written in the same word. With bit 19 at 0, bits 18:16 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 8 | Interrupt request lines, one per channel |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word write data |
| rd_data | output | 32 | Control word read view |
| cpu_irq | output | 1 | Machine external interrupt request to the CPU |

## Verification
The hardest state to reach is a queue of several pending channels being drained one acknowledge at a time. This has to be checked for every combination of lines, because the order in which channels are served depends on the whole pending set. The bench pulses all 255 non-zero request patterns in a single cycle. For each pattern it then acknowledges channels one by one and checks every served index against the lowest remaining bit, which it computes itself. Directed cases then cover the other hard-to-reach states: a lower channel arriving while a higher one is latched, withdrawal by disabling the served channel, and edges captured while the unit is off.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int CTRL_W      = 32;
  localparam int SRC_LSB     = 0;
  localparam int ACK_BIT     = 3;
  localparam int UNIT_EN_BIT = 4;
  localparam int CH_EN_LSB   = 8;
  localparam int SW_IDX_LSB  = 16;
  localparam int SW_GO_BIT   = 19;
endpackage

// File: rtl/irq_hub_edge.sv
module irq_hub_edge #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] req_i,
  output logic [NCH-1:0] rise_o
);
  logic [NCH-1:0] last_q;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) last_q[g] <= 1'b0;
      else     last_q[g] <= req_i[g];
    end
    assign rise_o[g] = req_i[g] & ~last_q[g];
  end
endmodule

// File: rtl/irq_hub_pend.sv
module irq_hub_pend #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] rise_i,
  input  logic [NCH-1:0] set_i,
  input  logic [NCH-1:0] clr_i,
  input  logic [NCH-1:0] keep_i,
  output logic [NCH-1:0] pend_o
);
  logic [NCH-1:0] pend_q;

  // new edges win over a simultaneous acknowledge; disabled lanes are dropped
  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= ((pend_q & ~clr_i) | rise_i | set_i) & keep_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_hub_pick.sv
module irq_hub_pick #(
  parameter int NCH  = 8,
  parameter int IDXW = $clog2(NCH)
) (
  input  logic [NCH-1:0]  req_i,
  output logic            valid_o,
  output logic [IDXW-1:0] idx_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IDXW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int IDXW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    irq_req,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] rd_data,
  output logic              cpu_irq
);
  logic            unit_en_q;
  logic [NCH-1:0]  ch_en_q;
  logic            busy_q;
  logic [IDXW-1:0] src_q;

  logic            unit_nx;
  logic [NCH-1:0]  ch_en_nx;
  logic            ack;
  logic [NCH-1:0]  rise;
  logic [NCH-1:0]  sw_set;
  logic [NCH-1:0]  clr;
  logic [NCH-1:0]  pend;
  logic            pick_vld;
  logic [IDXW-1:0] pick_idx;

  assign unit_nx  = wr_en ? wr_data[UNIT_EN_BIT] : unit_en_q;
  assign ch_en_nx = wr_en ? wr_data[CH_EN_LSB +: NCH] : ch_en_q;
  assign ack      = wr_en & wr_data[ACK_BIT] & busy_q;
  assign sw_set   = (wr_en && wr_data[SW_GO_BIT])
                    ? (NCH'(1) << wr_data[SW_IDX_LSB +: IDXW]) : '0;
  assign clr      = ack ? (NCH'(1) << src_q) : '0;

  irq_hub_edge #(.NCH(NCH)) u_edge (
    .clk(clk), .rst(rst), .req_i(irq_req), .rise_o(rise)
  );

  irq_hub_pend #(.NCH(NCH)) u_pend (
    .clk(clk), .rst(rst), .rise_i(rise), .set_i(sw_set),
    .clr_i(clr), .keep_i(ch_en_nx), .pend_o(pend)
  );

  irq_hub_pick #(.NCH(NCH), .IDXW(IDXW)) u_pick (
    .req_i(pend & ch_en_nx), .valid_o(pick_vld), .idx_o(pick_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      unit_en_q <= 1'b0;
      ch_en_q   <= '0;
    end else begin
      unit_en_q <= unit_nx;
      ch_en_q   <= ch_en_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      src_q  <= '0;
    end else if (busy_q) begin
      if (ack || !unit_nx || !ch_en_nx[src_q]) busy_q <= 1'b0;
    end else if (unit_nx && pick_vld) begin
      busy_q <= 1'b1;
      src_q  <= pick_idx;
    end
  end

  assign cpu_irq = busy_q;

  always_comb begin
    rd_data                           = '0;
    rd_data[SRC_LSB +: IDXW]          = src_q;
    rd_data[UNIT_EN_BIT]              = unit_en_q;
    rd_data[CH_EN_LSB +: NCH]         = ch_en_q;
  end

  // R3: no request reaches the CPU while the unit is off
  p_irq_needs_unit_r3: assert property (@(posedge clk) disable iff (rst)
    cpu_irq |-> unit_en_q);

  // R5: the served channel is still pending
  p_src_is_pending_r5: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> pend[src_q]);

  // R6: latched index is held while served
  p_src_held_r6: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q)) |-> $stable(src_q));

  // R7: an acknowledge drops the request on the next cycle
  p_ack_drops_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[ACK_BIT] && cpu_irq) |=> !cpu_irq);

  // R8: no pending flag survives on a disabled channel
  p_no_disabled_pend_r8: assert property (@(posedge clk) disable iff (rst)
    (pend & ~ch_en_q) == '0);
endmodule

// File: tb/irq_hub_bench.sv
module irq_hub_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  irq_req = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        cpu_irq;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;
  logic [31:0] cfg;

  irq_hub u_irq_hub (
    .clk(clk), .rst(rst), .irq_req(irq_req), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .cpu_irq(cpu_irq)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: act=%0d exp<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", rq, act, exp);
    end
  endtask

  // write lands at the next posedge; returns at the negedge after it
  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  // one-cycle pulse; returns at the negedge one cycle after the capture edge
  task automatic pulse(input logic [7:0] m);
    irq_req = m;
    @(negedge clk);
    irq_req = '0;
    @(negedge clk);
  endtask

  task automatic ack_next();
    wr(cfg | 32'h8);
    chk("R7 drop", {31'b0, cpu_irq}, 0);
    @(negedge clk);
  endtask

  function automatic int lowest(input logic [7:0] m);
    for (int i = 7; i >= 0; i--) if (m[i]) lowest = i;
  endfunction

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rd", rd_data, 0);
    chk("R1 irq", {31'b0, cpu_irq}, 0);

    // R2 readback
    cfg = 32'h0000_FF10;
    wr(cfg);
    chk("R2 rd", rd_data, cfg);
    wr(32'hFFF0_A5F0);
    chk("R2 masked", rd_data, 32'h0000_A510);
    wr(cfg);

    // R4 single channel sweep, held level not re-pended
    for (int n = 0; n < 8; n++) begin
      irq_req = 8'(1 << n);
      @(negedge clk); @(negedge clk);
      chk("R4 irq", {31'b0, cpu_irq}, 1);
      chk("R5 src", {29'b0, rd_data[2:0]}, n);
      ack_next();
      @(negedge clk);
      chk("R4 held level", {31'b0, cpu_irq}, 0);
      irq_req = '0;
      @(negedge clk);
    end

    // R5 exhaustive pattern drain
    for (int m = 1; m < 256; m++) begin
      logic [7:0] left;
      left = 8'(m);
      pulse(8'(m));
      while (left != 0) begin
        int e;
        e = lowest(left);
        chk("R5 irq", {31'b0, cpu_irq}, 1);
        chk("R5 order", {29'b0, rd_data[2:0]}, e);
        left[e] = 1'b0;
        ack_next();
      end
      chk("R7 empty", {31'b0, cpu_irq}, 0);
    end

    // R6 latched index held against lower arrival
    pulse(8'h20);
    pulse(8'h02);
    chk("R6 held", {29'b0, rd_data[2:0]}, 5);
    ack_next();
    chk("R6 next", {29'b0, rd_data[2:0]}, 1);
    ack_next();
    chk("R6 empty", {31'b0, cpu_irq}, 0);

    // R8 disabled channel ignores edges
    cfg = 32'h0000_DF10;
    wr(cfg);
    pulse(8'h20);
    chk("R8 ignore", {31'b0, cpu_irq}, 0);
    cfg = 32'h0000_FF10;
    wr(cfg);
    @(negedge clk);
    chk("R8 not kept", {31'b0, cpu_irq}, 0);

    // R8 disabling served channel withdraws and discards
    pulse(8'h08);
    chk("R8 pre", {31'b0, cpu_irq}, 1);
    wr(32'h0000_F710);
    chk("R8 withdraw", {31'b0, cpu_irq}, 0);
    wr(cfg);
    @(negedge clk);
    chk("R8 discard", {31'b0, cpu_irq}, 0);

    // R3 unit off captures, serves after enable
    cfg = 32'h0000_FF00;
    wr(cfg);
    pulse(8'h02);
    @(negedge clk);
    chk("R3 off", {31'b0, cpu_irq}, 0);
    cfg = 32'h0000_FF10;
    wr(cfg);
    chk("R3 on", {31'b0, cpu_irq}, 1);
    chk("R3 src", {29'b0, rd_data[2:0]}, 1);
    ack_next();

    // R9 software trigger sweep
    for (int n = 0; n < 8; n++) begin
      wr(cfg | 32'h0008_0000 | (32'(n) << 16));
      chk("R9 selfclear", rd_data & 32'h000F_0000, 0);
      @(negedge clk);
      chk("R9 irq", {31'b0, cpu_irq}, 1);
      chk("R9 src", {29'b0, rd_data[2:0]}, n);
      ack_next();
    end
    wr(cfg | 32'h0005_0000);
    @(negedge clk); @(negedge clk);
    chk("R9 no go", {31'b0, cpu_irq}, 0);
    wr(32'h0000_BF10 | 32'h0008_0000 | (32'd6 << 16));
    @(negedge clk);
    chk("R9 disabled", {31'b0, cpu_irq}, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule